// File: doc/BRIEF.md
# Hardware Standby Power Sequencer

This block walks an audio device into and out of hardware standby when an active-high standby pin toggles. Going down, it asks the output stages to fade to silence, powers down the headphone amplifier and the output bridge, forces every peripheral enable low, switches the system clock onto the crystal input and gates the clocks. When the deep mode is chosen, it also places the voltage regulator in standby as the last step.

Waking runs the same path backwards. In deep mode the sequencer first waits until the regulator reports it is ready. It then turns the clocks back on and reloads each peripheral enable from its live register bit. If the PLL was the selected clock, the sequencer waits for a stable lock. Finally it asks the output stages to fade back in, and it raises `ready` only once it is back in the operating state.

Each wait is a handshake. The fade steps end on done flags, the deep-mode output step ends on power-down acknowledges, and wake-up waits on the regulator-ready flag and a qualified PLL lock.

Top module: `stby_power_seq`

## Requirements
- R1: An active-low asynchronous reset puts the sequencer in the operating state (code 0) with `ready` high. All overrides are low, `clk_en` is high and `periph_en` equals `cfg_periph_en`.
- R2: The standby pin passes through SYNC_STAGES flops. The state leaves code 0 for the fade-out state (code 1) SYNC_STAGES+1 rising edges after the pin rises. State codes: 0 run, 1 fade-out, 2 output power-down, 3 peripherals off, 4 PLL bypass, 5 clocks off, 6 asleep, 7 regulator wake, 8 clocks on, 9 peripherals restored, 10 PLL wait, 11 fade-in.
- R3: `fade_out_req` is high only in state 1, which holds until `fade_out_done` is seen. `amp_pd` and `brg_pd` are then high in states 2 to 10.
- R4: The mode bits are captured when state 0 is left. In mild mode (`cfg_deep_mode`=0), state 2 lasts one cycle. In deep mode, state 2 holds until `amp_off_ack` and `brg_off_ack` are both high.
- R5: `cmp_pd` is high together with `amp_pd` when the captured `cfg_cmp_off` bit is 1.
- R6: `periph_en` is forced to zero in states 3 to 8. From state 9 on, it follows the current `cfg_periph_en`, including changes made during standby.
- R7: `pll_bypass` is high in states 4 to 10. `clk_en` is low in states 5, 6 and 7 only.
- R8: In deep mode `reg_stby` is high in state 6. Release then goes to state 7, which holds until `reg_ready` is seen before state 8. In mild mode, release goes from state 6 straight to state 8.
- R9: From state 9 the sequencer goes to state 10 when `cfg_pll_sel` is 1, and otherwise to state 11. State 10 ends after `pll_locked` has been high for LOCK_CYCLES consecutive cycles.
- R10: `fade_in_req` is high only in state 11, which holds until `fade_in_done` is seen and then returns to state 0. `ready` is high only in state 0.
- R11: If the pin is released during power-down, the current step still finishes. States 1 and 2 then continue to 11, states 3 and 4 to 9, and state 5 to 8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| stby_pin | input | 1 | Standby request pin, active high, asynchronous |
| cfg_deep_mode | input | 1 | 1 selects deep standby with regulator off |
| cfg_cmp_off | input | 1 | 1 also powers down the comparator cell |
| cfg_pll_sel | input | 1 | 1 when the PLL is the selected system clock |
| cfg_periph_en | input | N_PERIPH | Register-level peripheral enables |
| amp_off_ack | input | 1 | Amplifier reports it is powered down |
| brg_off_ack | input | 1 | Bridge reports it is powered down |
| reg_ready | input | 1 | Regulator reports its output is good |
| fade_out_done | input | 1 | Fade-out ramp has reached mute |
| fade_in_done | input | 1 | Fade-in ramp has reached operating volume |
| pll_locked | input | 1 | PLL lock indication |
| seq_state | output | 4 | Encoded sequencer state |
| ready | output | 1 | High in the operating state only |
| fade_out_req | output | 1 | Request to ramp output volume to mute |
| amp_pd | output | 1 | Amplifier power-down |
| brg_pd | output | 1 | Bridge power-down |
| cmp_pd | output | 1 | Comparator cell power-down |
| periph_en | output | N_PERIPH | Effective peripheral enables |
| pll_bypass | output | 1 | System clock taken from crystal input |
| clk_en | output | 1 | Global clock enable |
| reg_stby | output | 1 | Regulator standby |
| fade_in_req | output | 1 | Request to ramp output volume up |

## Verification
A change on the standby pin is due at the state and outputs SYNC_STAGES+1 rising edges later. Every other handshake input moves the state one edge after it is driven. The lock wait lasts LOCK_CYCLES+1 edges with lock held. All outputs decode from the state register in the same cycle as the state.

The bench drives each input on a falling edge and waits the exact number of rising edges that the step needs. It then compares the state and every output at the next falling edge. Steps that merely hold a wait check that the state has not moved after several extra edges.

// File: rtl/stby_power_pkg.sv
package stby_power_pkg;
   typedef enum logic [3:0] {
      ST_RUN      = 4'd0,
      ST_FADE_OUT = 4'd1,
      ST_OUT_PD   = 4'd2,
      ST_PER_OFF  = 4'd3,
      ST_BYPASS   = 4'd4,
      ST_CLK_OFF  = 4'd5,
      ST_SLEEP    = 4'd6,
      ST_REG_ON   = 4'd7,
      ST_CLK_ON   = 4'd8,
      ST_PER_ON   = 4'd9,
      ST_PLL_WAIT = 4'd10,
      ST_FADE_IN  = 4'd11
   } pwr_state_e;
endpackage

// File: rtl/stby_pin_sync.sv
module stby_pin_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   logic [STAGES-1:0] chain;

   if (STAGES < 2) begin : g_bad_stages
      $error("stby_pin_sync: STAGES must be at least 2");
   end

   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain[i] <= 1'b0;
         else        chain[i] <= (i == 0) ? d : chain[(i == 0) ? 0 : i-1];
      end
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/stby_lock_timer.sv
module stby_lock_timer #(
   parameter int LOCK_CYCLES = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   input  logic locked,
   output logic done
);
   if (LOCK_CYCLES < 0) begin : g_bad_lock
      $error("stby_lock_timer: LOCK_CYCLES must not be negative");
   end

   if (LOCK_CYCLES == 0) begin : g_direct
      assign done = en && locked;
   end else begin : g_count
      localparam int CW = $clog2(LOCK_CYCLES + 1);
      localparam logic [CW-1:0] LIMIT = CW'(LOCK_CYCLES);
      logic [CW-1:0] cnt;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)               cnt <= '0;
         else if (!en || !locked)  cnt <= '0;
         else if (cnt != LIMIT)    cnt <= cnt + 1'b1;
      end

      assign done = en && locked && (cnt == LIMIT);

      p_lock_restart_r9: assert property (@(posedge clk) disable iff (!rst_n)
         (en && !locked) |=> (cnt == '0));
   end
endmodule

// File: rtl/stby_power_seq.sv
module stby_power_seq
   import stby_power_pkg::*;
#(
   parameter int SYNC_STAGES = 2,
   parameter int LOCK_CYCLES = 4,
   parameter int N_PERIPH    = 4
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                stby_pin,
   input  logic                cfg_deep_mode,
   input  logic                cfg_cmp_off,
   input  logic                cfg_pll_sel,
   input  logic [N_PERIPH-1:0] cfg_periph_en,
   input  logic                amp_off_ack,
   input  logic                brg_off_ack,
   input  logic                reg_ready,
   input  logic                fade_out_done,
   input  logic                fade_in_done,
   input  logic                pll_locked,
   output logic [3:0]          seq_state,
   output logic                ready,
   output logic                fade_out_req,
   output logic                amp_pd,
   output logic                brg_pd,
   output logic                cmp_pd,
   output logic [N_PERIPH-1:0] periph_en,
   output logic                pll_bypass,
   output logic                clk_en,
   output logic                reg_stby,
   output logic                fade_in_req
);
   if (N_PERIPH < 1) begin : g_bad_periph
      $error("stby_power_seq: N_PERIPH must be at least 1");
   end

   pwr_state_e st_q, st_d;
   logic       stby_s;
   logic       deep_q, cmp_q;
   logic       lock_done;
   logic       out_ok;

   stby_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(stby_pin), .q(stby_s));

   stby_lock_timer #(.LOCK_CYCLES(LOCK_CYCLES)) u_lock (
      .clk(clk), .rst_n(rst_n), .en(st_q == ST_PLL_WAIT),
      .locked(pll_locked), .done(lock_done));

   assign out_ok = !deep_q || (amp_off_ack && brg_off_ack);

   always_comb begin
      st_d = st_q;
      unique case (st_q)
         ST_RUN:      if (stby_s) st_d = ST_FADE_OUT;
         ST_FADE_OUT: if (fade_out_done) st_d = stby_s ? ST_OUT_PD : ST_FADE_IN;
         ST_OUT_PD:   if (out_ok) st_d = stby_s ? ST_PER_OFF : ST_FADE_IN;
         ST_PER_OFF:  st_d = stby_s ? ST_BYPASS  : ST_PER_ON;
         ST_BYPASS:   st_d = stby_s ? ST_CLK_OFF : ST_PER_ON;
         ST_CLK_OFF:  st_d = stby_s ? ST_SLEEP   : ST_CLK_ON;
         ST_SLEEP:    if (!stby_s) st_d = deep_q ? ST_REG_ON : ST_CLK_ON;
         ST_REG_ON:   if (reg_ready) st_d = ST_CLK_ON;
         ST_CLK_ON:   st_d = ST_PER_ON;
         ST_PER_ON:   st_d = cfg_pll_sel ? ST_PLL_WAIT : ST_FADE_IN;
         ST_PLL_WAIT: if (lock_done) st_d = ST_FADE_IN;
         ST_FADE_IN:  if (fade_in_done) st_d = ST_RUN;
         default:     st_d = ST_RUN;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= ST_RUN;
         deep_q <= 1'b0;
         cmp_q  <= 1'b0;
      end else begin
         st_q <= st_d;
         if (st_q == ST_RUN && stby_s) begin
            deep_q <= cfg_deep_mode;
            cmp_q  <= cfg_cmp_off;
         end
      end
   end

   logic out_down, per_force, byp_on, clk_off;
   assign out_down  = (st_q >= ST_OUT_PD)  && (st_q <= ST_PLL_WAIT);
   assign per_force = (st_q >= ST_PER_OFF) && (st_q <= ST_CLK_ON);
   assign byp_on    = (st_q >= ST_BYPASS)  && (st_q <= ST_PLL_WAIT);
   assign clk_off   = (st_q >= ST_CLK_OFF) && (st_q <= ST_REG_ON);

   assign seq_state    = st_q;
   assign ready        = (st_q == ST_RUN);
   assign fade_out_req = (st_q == ST_FADE_OUT);
   assign fade_in_req  = (st_q == ST_FADE_IN);
   assign amp_pd       = out_down;
   assign brg_pd       = out_down;
   assign cmp_pd       = out_down && cmp_q;
   assign periph_en    = per_force ? '0 : cfg_periph_en;
   assign pll_bypass   = byp_on;
   assign clk_en       = !clk_off;
   assign reg_stby     = (st_q == ST_SLEEP) && deep_q;

   p_fade_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (fade_out_req && !fade_out_done) |=> fade_out_req);
   p_mild_pass_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_OUT_PD && !deep_q) |=> (st_q != ST_OUT_PD));
   p_deep_wait_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_OUT_PD && deep_q && !(amp_off_ack && brg_off_ack)) |=> (amp_pd && st_q == ST_OUT_PD));
   p_clk_force_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !clk_en |-> (periph_en == '0));
   p_reg_wait_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_REG_ON && !reg_ready) |=> !clk_en);
   p_reg_safe_r8: assert property (@(posedge clk) disable iff (!rst_n)
      reg_stby |-> (!clk_en && pll_bypass && amp_pd));
   p_lock_wait_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_PLL_WAIT && !pll_locked) |=> pll_bypass);
   p_fade_in_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (fade_in_req && fade_in_done) |=> ready);
endmodule

// File: tb/stby_power_seq_test.sv
module stby_power_seq_test;
   localparam int NP = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic stby_pin = 1'b0, cfg_deep_mode = 1'b0, cfg_cmp_off = 1'b0, cfg_pll_sel = 1'b0;
   logic [NP-1:0] cfg_periph_en = 4'hB;
   logic amp_off_ack = 1'b0, brg_off_ack = 1'b0, reg_ready = 1'b1;
   logic fade_out_done = 1'b0, fade_in_done = 1'b0, pll_locked = 1'b1;
   logic [3:0] seq_state;
   logic ready, fade_out_req, amp_pd, brg_pd, cmp_pd, pll_bypass, clk_en, reg_stby, fade_in_req;
   logic [NP-1:0] periph_en;

   int checks = 0;
   int errors = 0;

   always #4 clk = ~clk;

   stby_power_seq #(.SYNC_STAGES(2), .LOCK_CYCLES(4), .N_PERIPH(NP)) uut (
      .clk(clk), .rst_n(rst_n), .stby_pin(stby_pin), .cfg_deep_mode(cfg_deep_mode),
      .cfg_cmp_off(cfg_cmp_off), .cfg_pll_sel(cfg_pll_sel), .cfg_periph_en(cfg_periph_en),
      .amp_off_ack(amp_off_ack), .brg_off_ack(brg_off_ack), .reg_ready(reg_ready),
      .fade_out_done(fade_out_done), .fade_in_done(fade_in_done), .pll_locked(pll_locked),
      .seq_state(seq_state), .ready(ready), .fade_out_req(fade_out_req), .amp_pd(amp_pd),
      .brg_pd(brg_pd), .cmp_pd(cmp_pd), .periph_en(periph_en), .pll_bypass(pll_bypass),
      .clk_en(clk_en), .reg_stby(reg_stby), .fade_in_req(fade_in_req));

   // Expected outputs per state, from R1, R3, R5, R6, R7, R8, R10.
   function automatic logic [16:0] expect_out(input logic [3:0] st, input logic dp,
                                              input logic cm, input logic [NP-1:0] pc);
      logic pd, frc, byp, coff;
      pd   = (st >= 4'd2) && (st <= 4'd10);
      frc  = (st >= 4'd3) && (st <= 4'd8);
      byp  = (st >= 4'd4) && (st <= 4'd10);
      coff = (st >= 4'd5) && (st <= 4'd7);
      return {st, st == 4'd0, st == 4'd1, pd, pd, pd && cm, byp, !coff,
              (st == 4'd6) && dp, st == 4'd11, frc ? 4'h0 : pc};
   endfunction

   function automatic logic [16:0] actual_out();
      return {seq_state, ready, fade_out_req, amp_pd, brg_pd, cmp_pd, pll_bypass, clk_en,
              reg_stby, fade_in_req, periph_en};
   endfunction

   task automatic check(input logic [16:0] exp, input int rq, input string what);
      logic [16:0] act;
      act = actual_out();
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL R%0d %s: actual=%h expected=%h", rq, what, act, exp);
      end
   endtask

   // ctl bits: stby fod amp_ack brg_ack reg_ok lock fid pll_sel deep cmp
   typedef struct packed {
      logic [9:0] ctl;
      logic [3:0] pcfg;
      logic [3:0] cyc;
      logic [3:0] st;
      logic [3:0] rq;
   } vec_t;

   localparam int NV = 51;
   localparam vec_t VEC [NV] = '{
      // mild down, R2 R3 R4 R7
      '{10'b1000110000, 4'hB, 4'd3, 4'd1, 4'd2},
      '{10'b1000110000, 4'hB, 4'd5, 4'd1, 4'd3},
      '{10'b1100110000, 4'hB, 4'd1, 4'd2, 4'd3},
      '{10'b1000110000, 4'hB, 4'd1, 4'd3, 4'd4},
      '{10'b1000110000, 4'hB, 4'd1, 4'd4, 4'd7},
      '{10'b1000110000, 4'hB, 4'd1, 4'd5, 4'd7},
      '{10'b1000110000, 4'hB, 4'd1, 4'd6, 4'd7},
      // R6: register change during sleep stays forced
      '{10'b1000110000, 4'h6, 4'd5, 4'd6, 4'd6},
      // mild wake, R8 R6 R9 R10
      '{10'b0000110000, 4'h6, 4'd3, 4'd8, 4'd8},
      '{10'b0000110000, 4'h6, 4'd1, 4'd9, 4'd6},
      '{10'b0000110000, 4'h6, 4'd1, 4'd11, 4'd9},
      '{10'b0000110000, 4'h6, 4'd3, 4'd11, 4'd10},
      '{10'b0000111000, 4'h6, 4'd1, 4'd0, 4'd10},
      // deep with comparator and PLL, R4 R5 R8 R9
      '{10'b1000110111, 4'h6, 4'd3, 4'd1, 4'd2},
      '{10'b1100110111, 4'h6, 4'd1, 4'd2, 4'd5},
      '{10'b1000110111, 4'h6, 4'd4, 4'd2, 4'd4},
      '{10'b1010110111, 4'h6, 4'd2, 4'd2, 4'd4},
      '{10'b1011110111, 4'h6, 4'd1, 4'd3, 4'd4},
      '{10'b1011110111, 4'h6, 4'd1, 4'd4, 4'd7},
      '{10'b1011110111, 4'h6, 4'd1, 4'd5, 4'd7},
      '{10'b1011000111, 4'h6, 4'd1, 4'd6, 4'd8},
      '{10'b0011000111, 4'h6, 4'd3, 4'd7, 4'd8},
      '{10'b0011000111, 4'h6, 4'd3, 4'd7, 4'd8},
      '{10'b0011100111, 4'h6, 4'd1, 4'd8, 4'd8},
      '{10'b0011100111, 4'h6, 4'd1, 4'd9, 4'd6},
      '{10'b0011100111, 4'h6, 4'd1, 4'd10, 4'd9},
      '{10'b0011100111, 4'h6, 4'd3, 4'd10, 4'd9},
      '{10'b0011110111, 4'h6, 4'd4, 4'd10, 4'd9},
      '{10'b0011110111, 4'h6, 4'd1, 4'd11, 4'd9},
      '{10'b0011111111, 4'h6, 4'd1, 4'd0, 4'd10},
      // R11: release during fade-out
      '{10'b1000110000, 4'h6, 4'd3, 4'd1, 4'd2},
      '{10'b0000110000, 4'h6, 4'd3, 4'd1, 4'd11},
      '{10'b0100110000, 4'h6, 4'd1, 4'd11, 4'd11},
      '{10'b0000111000, 4'h6, 4'd1, 4'd0, 4'd10},
      // R11: release reaching peripherals-off and bypass
      '{10'b1000110000, 4'h6, 4'd3, 4'd1, 4'd2},
      '{10'b1100110000, 4'h6, 4'd1, 4'd2, 4'd3},
      '{10'b0000110000, 4'h6, 4'd3, 4'd9, 4'd11},
      '{10'b0000110000, 4'h6, 4'd1, 4'd11, 4'd9},
      '{10'b0000111000, 4'h6, 4'd1, 4'd0, 4'd10},
      // R11: deep release while waiting for acknowledges
      '{10'b1000110011, 4'h6, 4'd3, 4'd1, 4'd2},
      '{10'b1100110011, 4'h6, 4'd1, 4'd2, 4'd3},
      '{10'b0000110011, 4'h6, 4'd4, 4'd2, 4'd11},
      '{10'b0011110011, 4'h6, 4'd1, 4'd11, 4'd11},
      '{10'b0011111011, 4'h6, 4'd1, 4'd0, 4'd10},
      // R11: deep release reaching clocks-off skips regulator wake
      '{10'b1000110011, 4'h6, 4'd3, 4'd1, 4'd2},
      '{10'b1100110011, 4'h6, 4'd1, 4'd2, 4'd3},
      '{10'b1011110011, 4'h6, 4'd1, 4'd3, 4'd4},
      '{10'b0011110011, 4'h6, 4'd3, 4'd8, 4'd11},
      '{10'b0011110011, 4'h6, 4'd1, 4'd9, 4'd6},
      '{10'b0011110011, 4'h6, 4'd1, 4'd11, 4'd9},
      '{10'b0011111011, 4'h6, 4'd1, 4'd0, 4'd10}
   };

   task automatic finish_run();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   endtask

   initial begin
      repeat (30000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      finish_run();
   end

   initial begin
      logic ldeep, lcmp;
      ldeep = 1'b0;
      lcmp  = 1'b0;
      repeat (3) @(negedge clk);
      // R1: state during and after reset
      check(expect_out(4'd0, 1'b0, 1'b0, 4'hB), 1, "reset state");
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      check(expect_out(4'd0, 1'b0, 1'b0, 4'hB), 1, "idle after reset");

      for (int i = 0; i < NV; i++) begin
         {stby_pin, fade_out_done, amp_off_ack, brg_off_ack, reg_ready, pll_locked,
          fade_in_done, cfg_pll_sel, cfg_deep_mode, cfg_cmp_off} = VEC[i].ctl;
         cfg_periph_en = VEC[i].pcfg;
         if (VEC[i].st == 4'd1 && VEC[i].rq == 4'd2) begin
            ldeep = VEC[i].ctl[1];
            lcmp  = VEC[i].ctl[0];
         end
         for (int c = 0; c < int'(VEC[i].cyc); c++) @(posedge clk);
         @(negedge clk);
         check(expect_out(VEC[i].st, ldeep, lcmp, VEC[i].pcfg), int'(VEC[i].rq),
               $sformatf("vector %0d", i));
      end

      // R1: asynchronous reset in the middle of power-down
      fade_in_done = 1'b0;
      stby_pin = 1'b1;
      repeat (3) @(posedge clk);
      @(negedge clk);
      check(expect_out(4'd1, 1'b1, 1'b1, 4'h6), 2, "enter fade-out before reset");
      #1 rst_n = 1'b0;
      #1 check(expect_out(4'd0, 1'b0, 1'b0, 4'h6), 1, "async reset mid sequence");
      stby_pin = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      repeat (5) @(posedge clk);
      @(negedge clk);
      check(expect_out(4'd0, 1'b0, 1'b0, 4'h6), 1, "idle after second reset");
      finish_run();
   end
endmodule